// File: doc/BRIEF.md
# Recovered Reference Clock Output Selector

This block drives two reference clock outputs, A and B, each of which carries the recovered line clock of one of eight channels. Each output has its own 3-bit channel select. The two selects share one 6-bit control word: bits 2:0 steer output A and bits 5:3 steer output B. Every channel also reports a loss-of-signal (LOS) flag. When the channel that an output is following reports LOS, the output falls back to a substitute source. One control bit picks that source for both outputs: either a master-rate square wave or a steady logic high. When LOS clears, the output goes back to the channel clock.

The whole block runs in the master clock domain. Recovered clocks and LOS flags are asynchronous inputs, and both pass through a two-flop synchroniser before they are used. Each output has a current source and a wanted source. The current source only moves to the wanted source on a cycle where both of them sit low, so a change of select or an LOS event never produces a runt pulse. A constant-high source counts as low for this gate. Outputs come straight from a register. In nominal use the outputs run at 2.048 MHz (E1) or 1.544 MHz (T1/J1), well below the master clock.

Top module: `refclk_sel`

## Requirements
- R1: While `rst` is high, both `ref_a` and `ref_b` are held at 0.
- R2: `sel_cfg[2:0]` picks the channel index (0..7) for `ref_a`, and `sel_cfg[5:3]` picks the channel index for `ref_b`. The two selects act independently.
- R3: When the selected channel's LOS flag is 0 and the source has settled, the output equals that channel's `rec_clk` bit delayed by exactly 3 master clock cycles (two synchroniser flops plus the output register).
- R4: When the selected channel's LOS flag is 1 and `los_hold_high` is 1, the output settles to a constant 1.
- R5: When the selected channel's LOS flag is 1 and `los_hold_high` is 0, the output settles to the master-rate fallback wave, which changes level on every master clock cycle.
- R6: An output changes source only on a cycle where the old source and the new source are both low (a constant-high source counts as low). On the edge where a switch away from a non-high source is taken, the output is 0.
- R7: LOS flags of channels that an output does not select have no effect on that output.
- R8: When the LOS flag of the selected channel returns to 0, the output settles back to that channel's recovered clock, with the R3 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; every register in the block runs on it |
| rst | input | 1 | Synchronous active-high reset |
| rec_clk | input | 8 | Recovered clock of each line channel (asynchronous) |
| los | input | 8 | Loss-of-signal flag of each channel (asynchronous, 1 = lost) |
| sel_cfg | input | 6 | Channel select word: bits 2:0 for output A, bits 5:3 for output B |
| los_hold_high | input | 1 | Fallback choice on LOS: 1 = steady high, 0 = master-rate wave |
| ref_a | output | 1 | Reference clock output A (registered) |
| ref_b | output | 1 | Reference clock output B (registered) |

## Verification
The assertions assume that every recovered clock is slow compared with the master clock, so each level lasts for several master cycles after synchronisation. They also assume that selects and LOS flags are quasi-static. Under these assumptions, any source switch happens on a low-low cycle, and the fallback wave toggles cleanly once it is in place. The stimulus generates channel clocks with half periods of 2 to 9 master cycles, each channel with a different period. It changes selects, LOS flags and the fallback bit only between observation windows, and it leaves a settling time long enough for the low-low gate to open before any compare starts.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  localparam int IDX_W   = 3;
  localparam int NCH_DEF = 8;

  typedef enum logic [1:0] {
    SRC_CH   = 2'd0,
    SRC_MCLK = 2'd1,
    SRC_HIGH = 2'd2
  } src_kind_e;

  typedef struct packed {
    src_kind_e        kind;
    logic [IDX_W-1:0] ch;
  } src_t;

endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/refsel_lane.sv
module refsel_lane
  import refsel_pkg::*;
#(
  parameter int NCH = NCH_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   lvl_i,
  input  logic [NCH-1:0]   los_i,
  input  logic [IDX_W-1:0] sel_i,
  input  logic             hold_hi_i,
  input  logic             fb_i,
  output logic             ref_o,
  output src_t             src_o
);

  src_t cur_q;
  src_t want;
  logic cur_lvl;
  logic want_lvl;
  logic cur_gate;
  logic want_gate;
  logic ref_q;

  // Wanted source: the selected channel, or the fallback while it reports LOS
  always_comb begin
    want.ch = sel_i;
    if (los_i[sel_i]) begin
      want.kind = hold_hi_i ? SRC_HIGH : SRC_MCLK;
    end else begin
      want.kind = SRC_CH;
    end
  end

  always_comb begin
    unique case (cur_q.kind)
      SRC_CH:   cur_lvl = lvl_i[cur_q.ch];
      SRC_MCLK: cur_lvl = fb_i;
      default:  cur_lvl = 1'b1;
    endcase
    unique case (want.kind)
      SRC_CH:   want_lvl = lvl_i[want.ch];
      SRC_MCLK: want_lvl = fb_i;
      default:  want_lvl = 1'b1;
    endcase
    // a steady-high source never opens a low window, so it is treated as low
    cur_gate  = (cur_q.kind == SRC_HIGH) || !cur_lvl;
    want_gate = (want.kind  == SRC_HIGH) || !want_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '{kind: SRC_CH, ch: '0};
      ref_q <= 1'b0;
    end else begin
      ref_q <= cur_lvl;
      if ((want != cur_q) && cur_gate && want_gate) cur_q <= want;
    end
  end

  assign ref_o = ref_q;
  assign src_o = cur_q;

endmodule

// File: rtl/refclk_sel.sv
module refclk_sel
  import refsel_pkg::*;
#(
  parameter int NCH         = NCH_DEF,
  parameter int SYNC_STAGES = 2,
  parameter int NOUT        = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        rec_clk,
  input  logic [NCH-1:0]        los,
  input  logic [NOUT*IDX_W-1:0] sel_cfg,
  input  logic                  los_hold_high,
  output logic                  ref_a,
  output logic                  ref_b
);

  localparam int SELW = IDX_W;

  logic [NCH-1:0] rec_s;
  logic [NCH-1:0] los_s;
  logic           fb_q;
  logic [NOUT-1:0] ref_w;
  src_t           src_w [NOUT];
  src_t           src_a;
  src_t           src_b;

  refsel_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_rec_sync (
    .clk (clk),
    .rst (rst),
    .d_i (rec_clk),
    .q_o (rec_s)
  );

  refsel_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_los_sync (
    .clk (clk),
    .rst (rst),
    .d_i (los),
    .q_o (los_s)
  );

  // master-rate fallback wave, rebuilt as a registered level
  always_ff @(posedge clk) begin
    if (rst) fb_q <= 1'b0;
    else     fb_q <= ~fb_q;
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_lane
    refsel_lane #(.NCH(NCH)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .lvl_i     (rec_s),
      .los_i     (los_s),
      .sel_i     (sel_cfg[g*SELW +: SELW]),
      .hold_hi_i (los_hold_high),
      .fb_i      (fb_q),
      .ref_o     (ref_w[g]),
      .src_o     (src_w[g])
    );
  end

  assign ref_a = ref_w[0];
  assign ref_b = ref_w[1];
  assign src_a = src_w[0];
  assign src_b = src_w[1];

endmodule

// File: rtl/refclk_sel_chk.sv
module refclk_sel_chk
  import refsel_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic ref_a,
  input logic ref_b,
  input src_t src_a,
  input src_t src_b
);

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> (ref_a == 1'b0 && ref_b == 1'b0)); // R1

  AST_SWITCH_LOW_A: assert property (@(posedge clk) disable iff (rst)
    (src_a != $past(src_a)) && ($past(src_a.kind) != SRC_HIGH) |-> (ref_a == 1'b0)); // R6

  AST_SWITCH_LOW_B: assert property (@(posedge clk) disable iff (rst)
    (src_b != $past(src_b)) && ($past(src_b.kind) != SRC_HIGH) |-> (ref_b == 1'b0)); // R6

  AST_HOLD_HIGH_A: assert property (@(posedge clk) disable iff (rst)
    (src_a.kind == SRC_HIGH) |=> (ref_a == 1'b1)); // R4

  AST_HOLD_HIGH_B: assert property (@(posedge clk) disable iff (rst)
    (src_b.kind == SRC_HIGH) |=> (ref_b == 1'b1)); // R4

  AST_FB_TOGGLE_A: assert property (@(posedge clk) disable iff (rst)
    (src_a.kind == SRC_MCLK) && ($past(src_a.kind) == SRC_MCLK) |=> (ref_a != $past(ref_a))); // R5

  AST_FB_TOGGLE_B: assert property (@(posedge clk) disable iff (rst)
    (src_b.kind == SRC_MCLK) && ($past(src_b.kind) == SRC_MCLK) |=> (ref_b != $past(ref_b))); // R5

endmodule

bind refclk_sel refclk_sel_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .ref_a (ref_a),
  .ref_b (ref_b),
  .src_a (src_a),
  .src_b (src_b)
);

// File: tb/refclk_sel_tb.sv
`timescale 1ns/1ps
module refclk_sel_tb;

  localparam int NCH   = 8;
  localparam int KCH   = 0;
  localparam int KHIGH = 1;
  localparam int KTOG  = 2;

  typedef struct {
    int    ka;
    int    cha;
    int    kb;
    int    chb;
    int    n;
    string tag;
  } item_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] rec_clk = '0;
  logic [NCH-1:0] los = '0;
  logic [5:0]     sel_cfg = '0;
  logic           los_hold_high = 1'b0;
  logic           ref_a;
  logic           ref_b;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [NCH-1:0] h0 = '0, h1 = '0, h2 = '0;
  item_t q[$];

  always #2.5 clk = ~clk;

  refclk_sel u_dut (
    .clk           (clk),
    .rst           (rst),
    .rec_clk       (rec_clk),
    .los           (los),
    .sel_cfg       (sel_cfg),
    .los_hold_high (los_hold_high),
    .ref_a         (ref_a),
    .ref_b         (ref_b)
  );

  // channel i toggles every i+2 cycles, changed just after the edge
  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    for (int i = 0; i < NCH; i++) rec_clk[i] = ((cyc / (i + 2)) % 2) == 1;
  end

  // values seen at each edge; h2 is what the output shows now
  always @(posedge clk) begin
    h0 <= rec_clk;
    h1 <= h0;
    h2 <= h1;
  end

  task automatic check_lane(input string nm, input logic act, input logic prv,
                            input int k, input int ch, input string tag);
    logic exp;
    if (k == KCH)        exp = h2[ch];
    else if (k == KHIGH) exp = 1'b1;
    else                 exp = ~prv;
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s ref_%s: actual=%0b expected=%0b (kind %0d ch %0d)", tag, nm, act, exp, k, ch);
    end
  endtask

  // monitor: pops expected windows and compares cycle by cycle
  initial begin
    item_t it;
    logic pa, pb;
    forever begin
      wait (q.size() > 0);
      it = q.pop_front();
      @(negedge clk);
      pa = ref_a;
      pb = ref_b;
      for (int c = 0; c < it.n; c++) begin
        @(negedge clk);
        check_lane("a", ref_a, pa, it.ka, it.cha, it.tag);
        check_lane("b", ref_b, pb, it.kb, it.chb, it.tag);
        pa = ref_a;
        pb = ref_b;
      end
    end
  end

  // driver: applies a setting, lets it settle, then queues the expectation
  task automatic apply(input int sa, input int sb, input logic [NCH-1:0] lv,
                       input logic hh, input int ka, input int kb, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    sel_cfg       = {sb[2:0], sa[2:0]};
    los           = lv;
    los_hold_high = hh;
    repeat (80) @(posedge clk);
    it = '{ka: ka, cha: sa, kb: kb, chb: sb, n: 40, tag: tag};
    q.push_back(it);
    repeat (45) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: outputs low while reset is held
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      total++;
      if (ref_a !== 1'b0 || ref_b !== 1'b0) begin
        bad++;
        $display("FAIL R1 reset: actual=%0b%0b expected=00", ref_a, ref_b);
      end
    end
    @(posedge clk);
    #1 rst = 1'b0;

    // R2 R3: every select value on both outputs, independent choices
    for (int s = 0; s < NCH; s++) begin
      apply(s, (s + 3) % NCH, '0, 1'b0, KCH, KCH, "R2_R3");
    end
    apply(6, 6, '0, 1'b0, KCH, KCH, "R2_same");

    // R4 R7: LOS on A's channel, B unaffected
    apply(2, 5, 8'b0000_0100, 1'b1, KHIGH, KCH, "R4_R7");
    // R5: master-rate fallback
    apply(2, 5, 8'b0000_0100, 1'b0, KTOG, KCH, "R5");
    // R6: switching from the fallback wave to steady high (gate with high source)
    apply(2, 5, 8'b0000_0100, 1'b1, KHIGH, KCH, "R6");
    // R8: LOS removed, back to the channel clock
    apply(2, 5, 8'b0000_0000, 1'b1, KCH, KCH, "R8");

    // R7: LOS on unselected channels and on B's channel only
    apply(2, 5, 8'b1010_0001, 1'b1, KCH, KHIGH, "R7_R4");
    apply(2, 5, 8'b1010_0001, 1'b0, KCH, KTOG, "R7_R5");
    apply(2, 5, 8'b0010_0100, 1'b0, KTOG, KTOG, "R5_both");
    apply(2, 5, 8'b0010_0100, 1'b1, KHIGH, KHIGH, "R4_both");
    apply(2, 5, 8'b0000_0000, 1'b0, KCH, KCH, "R8_both");
    // R6 R3: reselect while running
    apply(7, 0, 8'b0000_0000, 1'b0, KCH, KCH, "R6_R3");

    repeat (5) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule